// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical one. It walks a tree of page tables that is three levels deep, and it reads every 64-bit table entry through one memory read port. A requester starts a walk with a single-cycle start request. The request carries the virtual address, the kind of access (read, write or execute) and whether the access is made in user mode. The block also samples the frame of the top-level table and the page-size exponent at that moment. The block works on one walk at a time. It holds `busy` high while the walk runs. It then gives a one-cycle `done` pulse. With that pulse it presents either a physical address with the page-size exponent that applies, or a fault code.

Each table level is indexed by `page_shift - 3` bits of the virtual address. Level 3 sits right above the page offset, level 2 above level 3, and level 1 at the top. An entry at an upper level supplies only the frame of the next table, and it must be valid and readable in kernel mode. The leaf entry is also checked against the requester's mode and access kind, and then against its fault-on-access bits. A 2-bit granularity hint in the leaf can make the reported page size larger. An address that is not a proper sign-extension of the implemented width is refused at once, without any memory read.

Top module: `pt_walker3`

## Requirements
- R1: If bits 63 down to VA_BITS-1 of the virtual address are not all equal (VA_BITS defaults to 43), the walk ends with fault code 2 (access violation). `done` rises in the cycle after the start is taken, and no memory read is issued.
- R2: The read address for a level is (table frame << page_shift) + 8 × index. The level-3 index is vaddr bits [page_shift + L - 1 : page_shift], where L = page_shift - 3. The level-2 index is the next L bits above that, and the level-1 index is the L bits above level 2.
- R3: Reads go in the order level 1, level 2, level 3. Level 1 uses `root_frame`. Each later level uses bits 63:32 of the entry just read as its table frame.
- R4: At level 1 or level 2, an entry with bit 0 (valid) clear ends the walk with fault code 1 (not valid). An entry with bit 8 (kernel read) clear ends it with fault code 2. No further reads follow either fault.
- R5: A leaf entry with bit 0 clear gives fault code 1.
- R6: Access kind 2'b00 is read, 2'b01 is write, and 2'b10 or 2'b11 is execute. Read and execute need bit 9 (user mode) or bit 8 (kernel mode). Write needs bit 13 (user) or bit 12 (kernel). A missing enable gives fault code 2.
- R7: Once the permission check passes, a leaf with bit 1 set faults a read with code 3. Bit 2 faults a write with code 4, and bit 3 faults an execute with code 5. A fault-on bit for a different access kind has no effect, and the result is code 0 (no fault).
- R8: A walk with no fault gives res_paddr = (leaf bits 63:32 << page_shift) | (vaddr mod 2^page_shift). It also gives res_shift = page_shift + 3 × leaf bits 6:5.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. `busy` stays high from the cycle after a start until `done`. `done` lasts one cycle, with `busy` low. A start request made while busy is ignored.
- R10: When the fault code is not zero, res_paddr and res_shift are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | 00 read, 01 write, 1x execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| root_frame | input | 32 | Frame of the level-1 table, sampled at start |
| page_shift | input | 5 | Page-size exponent, sampled at start |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| res_fault | output | 3 | 0 none, 1 not valid, 2 access violation, 3/4/5 fault on read/write/execute |
| res_paddr | output | 64 | Translated physical address |
| res_shift | output | 6 | Effective page-size exponent |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
The bench goes after the fault ordering at the leaf. A design that checks the fault-on bits before the enables would report fault on read where an access violation is due. A design that ignores the access kind would fault a read on a fault-on-execute bit. Upper-level entries that are not valid or not kernel-readable must stop the walk after one or two reads; a walker that carries on issues extra reads and reports the wrong code. The bench also checks that one bit just above the implemented width is refused with no read, that the granularity hint scales the exponent by three per step while the offset still uses the base page size, and that a start pulsed during a stalled read leaves the walk untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry layout (fixed 64-bit format)
  localparam int ADDR_W   = 64;
  localparam int PTE_W    = 64;
  localparam int FRAME_W  = 32;
  localparam int FRAME_LO = 32;
  localparam int PB_W     = 5;
  localparam int ZB_W     = 6;
  localparam int LEVELS   = 3;
  localparam int LVL_W    = $clog2(LEVELS);

  localparam int B_VALID = 0;
  localparam int B_FOR   = 1;
  localparam int B_FOW   = 2;
  localparam int B_FOE   = 3;
  localparam int B_GH    = 5;
  localparam int B_KRE   = 8;
  localparam int B_URE   = 9;
  localparam int B_KWE   = 12;
  localparam int B_UWE   = 13;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_TNV  = 3'd1,
    FLT_ACV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  // Index bits for level lvl (0 = top level, LEVELS-1 = leaf)
  function automatic logic [ADDR_W-1:0] level_index(input logic [ADDR_W-1:0] va,
                                                    input logic [PB_W-1:0] pb,
                                                    input logic [LVL_W-1:0] lvl);
    logic [6:0] lb;
    logic [6:0] sh;
    lb = {2'b00, pb} - 7'd3;
    sh = {2'b00, pb} + lb * (7'(LEVELS - 1) - 7'(lvl));
    return (va >> sh) & ((64'd1 << lb) - 64'd1);
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                   input logic [PB_W-1:0] pb,
                                                   input logic [ADDR_W-1:0] idx);
    return ({{(ADDR_W-FRAME_W){1'b0}}, frame} << pb) + (idx << 3);
  endfunction

  function automatic logic [ADDR_W-1:0] leaf_paddr(input logic [FRAME_W-1:0] frame,
                                                   input logic [PB_W-1:0] pb,
                                                   input logic [ADDR_W-1:0] va);
    return ({{(ADDR_W-FRAME_W){1'b0}}, frame} << pb) | (va & ((64'd1 << pb) - 64'd1));
  endfunction

  function automatic logic [ZB_W-1:0] eff_shift(input logic [PB_W-1:0] pb,
                                                input logic [1:0] gh);
    return {1'b0, pb} + ({4'b0000, gh} * 6'd3);
  endfunction
endpackage

// File: rtl/ptw_vcheck.sv
module ptw_vcheck #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 43
) (
  input  logic [ADDR_W-1:0] va,
  output logic              va_ok
);
  generate
    if (VA_BITS >= ADDR_W) begin : g_full
      logic unused_va;
      assign unused_va = ^va;
      assign va_ok = 1'b1;
    end else begin : g_sext
      localparam int TOP_W = ADDR_W - VA_BITS + 1;
      logic [TOP_W-1:0] top_bits;
      logic             unused_low;
      assign top_bits   = va[ADDR_W-1:VA_BITS-1];
      assign unused_low = ^va[VA_BITS-2:0];
      assign va_ok      = (&top_bits) | ~(|top_bits);
    end
  endgenerate
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0]  va,
  input  logic [PB_W-1:0]    pb,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LVL_W-1:0]   lvl,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] idx;
  assign idx  = level_index(va, pb, lvl);
  assign addr = entry_addr(frame, pb, idx);
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             leaf,
  input  logic [1:0]       access,
  input  logic             user,
  output fault_e           fault
);
  logic is_wr, is_ex, is_rd, rd_ok, wr_ok;
  logic unused_pte;

  assign is_ex = access[1];
  assign is_wr = (access == 2'b01);
  assign is_rd = (access == 2'b00);
  assign rd_ok = user ? pte[B_URE] : pte[B_KRE];
  assign wr_ok = user ? pte[B_UWE] : pte[B_KWE];
  assign unused_pte = ^{pte[PTE_W-1:14], pte[11:10], pte[7:4]};

  always_comb begin
    if (!pte[B_VALID])                    fault = FLT_TNV;
    else if (!leaf)                       fault = pte[B_KRE] ? FLT_NONE : FLT_ACV;
    else if (is_wr ? !wr_ok : !rd_ok)     fault = FLT_ACV;
    else if (is_ex && pte[B_FOE])         fault = FLT_FOE;
    else if (is_wr && pte[B_FOW])         fault = FLT_FOW;
    else if (is_rd && pte[B_FOR])         fault = FLT_FOR;
    else                                  fault = FLT_NONE;
  end
endmodule

// File: rtl/pt_walker3.sv
module pt_walker3
  import ptw_pkg::*;
#(
  parameter int VA_BITS = 43
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [1:0]          req_access,
  input  logic                req_user,
  input  logic [FRAME_W-1:0]  root_frame,
  input  logic [PB_W-1:0]     page_shift,
  output logic                busy,
  output logic                done,
  output logic [2:0]          res_fault,
  output logic [ADDR_W-1:0]   res_paddr,
  output logic [ZB_W-1:0]     res_shift,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  localparam logic [LVL_W-1:0] LEAF_LVL = LVL_W'(LEVELS - 1);

  state_e             st;
  logic [LVL_W-1:0]   walk_lvl;
  logic [ADDR_W-1:0]  va_q;
  logic [1:0]         acc_q;
  logic               user_q;
  logic [PB_W-1:0]    pb_q;
  logic [FRAME_W-1:0] frame_q;
  logic               done_q;
  fault_e             fault_q;
  logic [ADDR_W-1:0]  paddr_q;
  logic [ZB_W-1:0]    shift_q;

  // Named events for the checker
  logic   accept, va_ok, mem_fire, rsp_fire, at_leaf;
  fault_e chk_fault;

  assign accept   = req_valid && (st == S_IDLE);
  assign mem_fire = mem_req_valid && mem_req_ready;
  assign rsp_fire = (st == S_WAIT) && mem_rsp_valid;
  assign at_leaf  = (walk_lvl == LEAF_LVL);

  ptw_vcheck #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_vchk (
    .va(req_vaddr), .va_ok(va_ok)
  );

  ptw_addr u_addr (
    .va(va_q), .pb(pb_q), .frame(frame_q), .lvl(walk_lvl), .addr(mem_req_addr)
  );

  ptw_perm u_perm (
    .pte(mem_rsp_data), .leaf(at_leaf), .access(acc_q), .user(user_q), .fault(chk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      walk_lvl <= '0;
      va_q     <= '0;
      acc_q    <= '0;
      user_q   <= 1'b0;
      pb_q     <= '0;
      frame_q  <= '0;
      done_q   <= 1'b0;
      fault_q  <= FLT_NONE;
      paddr_q  <= '0;
      shift_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept) begin
            va_q     <= req_vaddr;
            acc_q    <= req_access;
            user_q   <= req_user;
            pb_q     <= page_shift;
            frame_q  <= root_frame;
            walk_lvl <= '0;
            if (!va_ok) begin
              done_q  <= 1'b1;
              fault_q <= FLT_ACV;
              paddr_q <= '0;
              shift_q <= '0;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_fire) begin
            if (chk_fault != FLT_NONE) begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              fault_q <= chk_fault;
              paddr_q <= '0;
              shift_q <= '0;
            end else if (at_leaf) begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              fault_q <= FLT_NONE;
              paddr_q <= leaf_paddr(mem_rsp_data[FRAME_LO +: FRAME_W], pb_q, va_q);
              shift_q <= eff_shift(pb_q, mem_rsp_data[B_GH +: 2]);
            end else begin
              frame_q  <= mem_rsp_data[FRAME_LO +: FRAME_W];
              walk_lvl <= walk_lvl + 1'b1;
              st       <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign done          = done_q;
  assign res_fault     = fault_q;
  assign res_paddr     = paddr_q;
  assign res_shift     = shift_q;
  assign mem_req_valid = (st == S_ISSUE);
endmodule

// File: rtl/pt_walker3_chk.sv
module pt_walker3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        va_ok,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_fire,
  input logic        rsp_fire,
  input logic [1:0]  walk_lvl,
  input logic        busy,
  input logic        done,
  input logic [2:0]  res_fault,
  input logic [63:0] res_paddr,
  input logic [5:0]  res_shift
);
  AST_SEXT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !va_ok |=> done && (res_fault == 3'd2)); // R1
  AST_SEXT_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !va_ok |=> !mem_req_valid && !busy); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> walk_lvl <= 2'd2); // R3
  AST_RSP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |-> busy && !mem_req_valid); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R9
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && (res_fault != 3'd0) |-> (res_paddr == 64'd0) && (res_shift == 6'd0)); // R10
endmodule

bind pt_walker3 pt_walker3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .va_ok(va_ok),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_fire(mem_fire), .rsp_fire(rsp_fire),
  .walk_lvl(walk_lvl), .busy(busy), .done(done), .res_fault(res_fault),
  .res_paddr(res_paddr), .res_shift(res_shift)
);

// File: tb/tb_pt_walker3.sv
`timescale 1ns/1ps
module tb_pt_walker3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_access = '0;
  logic        req_user = 1'b0;
  logic [31:0] root_frame = '0;
  logic [4:0]  page_shift = 5'd13;
  logic        busy, done;
  logic [2:0]  res_fault;
  logic [63:0] res_paddr;
  logic [5:0]  res_shift;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pt_walker3 dut (.*);

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic [63:0] p1;
    logic [63:0] p2;
    logic [63:0] p3;
    logic [2:0]  flt;
    logic [1:0]  nrd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R8 kernel read, clean leaf
    '{64'h0000_0012_3456_789A, 2'b00, 1'b0, {32'h51, 32'h101}, {32'h62, 32'h101}, {32'h7_7777, 32'h3301}, 3'd0, 2'd3, 4'd8},
    // R6 user write permitted by user write enable, negative half
    '{64'hFFFF_FC00_0000_1234, 2'b01, 1'b1, {32'h52, 32'h101}, {32'h63, 32'h101}, {32'h1_2345, 32'h2201}, 3'd0, 2'd3, 4'd6},
    // R6 user read with only kernel read
    '{64'h0000_0001_0000_2000, 2'b00, 1'b1, {32'h53, 32'h101}, {32'h64, 32'h101}, {32'h99, 32'h0101}, 3'd2, 2'd3, 4'd6},
    // R7 execute with fault-on-execute
    '{64'h0000_0003_0204_0608, 2'b10, 1'b0, {32'h54, 32'h101}, {32'h65, 32'h101}, {32'h88, 32'h3309}, 3'd5, 2'd3, 4'd7},
    // R7 read with fault-on-read
    '{64'h0000_0000_0040_0010, 2'b00, 1'b1, {32'h55, 32'h101}, {32'h66, 32'h101}, {32'h77, 32'h3303}, 3'd3, 2'd3, 4'd7},
    // R7 write with fault-on-write
    '{64'h0000_0200_0000_0000, 2'b01, 1'b0, {32'h56, 32'h101}, {32'h67, 32'h101}, {32'h66, 32'h3305}, 3'd4, 2'd3, 4'd7},
    // R4 level 2 not valid
    '{64'h0000_0010_0800_4000, 2'b00, 1'b0, {32'h57, 32'h101}, {32'h68, 32'h100}, {32'h55, 32'h3301}, 3'd1, 2'd2, 4'd4},
    // R4 level 1 valid but not kernel readable
    '{64'h0000_0020_0000_0000, 2'b00, 1'b0, {32'h58, 32'h001}, {32'h69, 32'h101}, {32'h44, 32'h3301}, 3'd2, 2'd1, 4'd4},
    // R5 leaf not valid
    '{64'h0000_0005_5555_5555, 2'b00, 1'b0, {32'h59, 32'h101}, {32'h6A, 32'h101}, {32'h33, 32'h3300}, 3'd1, 2'd3, 4'd5},
    // R1 bit 42 set, upper bits clear
    '{64'h0000_0400_0000_0000, 2'b00, 1'b0, {32'h5A, 32'h101}, {32'h6B, 32'h101}, {32'h22, 32'h3301}, 3'd2, 2'd0, 4'd1},
    // R6 kernel write without kernel write enable
    '{64'h0000_0000_1234_5678, 2'b01, 1'b0, {32'h5B, 32'h101}, {32'h6C, 32'h101}, {32'h11, 32'h2301}, 3'd2, 2'd3, 4'd6},
    // R7 fault-on-execute ignored by a read (execute code 2'b11 elsewhere)
    '{64'h0000_0000_0000_1FFF, 2'b00, 1'b0, {32'h5C, 32'h101}, {32'h6D, 32'h101}, {32'hABCD, 32'h3309}, 3'd0, 2'd3, 4'd7}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pow2(input int n);
    return 64'd1 << n;
  endfunction

  // Bench-side restatement of the table address for level l (0 = top)
  function automatic logic [63:0] want_addr(input logic [63:0] va, input int pb,
                                            input logic [31:0] frame, input int l);
    logic [63:0] idx;
    idx = (va / pow2(pb + (2 - l) * (pb - 3))) % pow2(pb - 3);
    return 64'(frame) * pow2(pb) + idx * 64'd8;
  endfunction

  task automatic walk(input string tag, input logic [63:0] va, input logic [1:0] acc,
                      input logic usr, input logic [31:0] root, input int pb,
                      input logic [63:0] p1, input logic [63:0] p2, input logic [63:0] p3,
                      input logic [2:0] eflt, input int enrd, input int stall, input bit poke);
    logic [63:0] ptes [3];
    logic [31:0] frames [3];
    logic [63:0] a0;
    int reads = 0;
    int guard = 0;
    bit seen = 0;
    ptes[0] = p1; ptes[1] = p2; ptes[2] = p3;
    frames[0] = root; frames[1] = p1[63:32]; frames[2] = p2[63:32];
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_access = acc; req_user = usr;
    root_frame = root; page_shift = 5'(pb);
    @(negedge clk);
    req_valid = 1'b0;
    while (!seen && guard < 100) begin
      guard++;
      if (done) begin
        seen = 1;
      end else if (mem_req_valid) begin
        a0 = mem_req_addr;
        check(reads < 3 && a0 == want_addr(va, pb, frames[reads < 3 ? reads : 2], reads < 3 ? reads : 2),
              {tag, " R2 R3 read address"}, a0,
              want_addr(va, pb, frames[reads < 3 ? reads : 2], reads < 3 ? reads : 2));
        for (int s = 0; s < stall; s++) begin
          if (poke && s == 0) begin
            req_valid = 1'b1; req_vaddr = 64'h8000_0000_0000_0000; req_access = 2'b01;
          end
          @(negedge clk);
          req_valid = 1'b0; req_vaddr = va; req_access = acc;
          check(mem_req_valid && mem_req_addr == a0 && busy && !done,
                {tag, " R9 request held"}, mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = ptes[reads < 3 ? reads : 2];
        reads++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
      end else begin
        @(negedge clk);
      end
    end
    check(seen, {tag, " R9 done seen"}, 64'(seen), 64'd1);
    check(reads == enrd, {tag, " R3 R4 read count"}, 64'(reads), 64'(enrd));
    check(res_fault == eflt, {tag, " fault code"}, 64'(res_fault), 64'(eflt));
    check(!busy, {tag, " R9 busy low at done"}, 64'(busy), 64'd0);
    if (eflt == 3'd0) begin
      check(res_paddr == 64'(p3[63:32]) * pow2(pb) + (va % pow2(pb)),
            {tag, " R8 paddr"}, res_paddr, 64'(p3[63:32]) * pow2(pb) + (va % pow2(pb)));
      check(res_shift == 6'(pb + 3 * int'(p3[6:5])), {tag, " R8 shift"},
            64'(res_shift), 64'(pb + 3 * int'(p3[6:5])));
    end else begin
      check(res_paddr == 0 && res_shift == 0, {tag, " R10 zero on fault"}, res_paddr, 64'd0);
    end
    @(negedge clk);
    check(!done, {tag, " R9 done one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // Reset state
    check(!busy && !done && !mem_req_valid, "R9 reset outputs idle", {61'd0, busy, done, mem_req_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req_valid, "R9 idle after reset", 64'(busy), 64'd0);

    for (int i = 0; i < NV; i++) begin
      walk($sformatf("vec%0d R%0d", i, VECS[i].req), VECS[i].va, VECS[i].acc, VECS[i].usr,
           32'h40, 13, VECS[i].p1, VECS[i].p2, VECS[i].p3, VECS[i].flt, int'(VECS[i].nrd),
           i % 3, 1'b0);
    end

    // R8 granularity hint 3 at 64 KiB pages, offset still uses base page size
    walk("R8 hint", 64'h0000_0012_3456_FEDC, 2'b00, 1'b0, 32'h300, 16,
         {32'h10, 32'h101}, {32'h20, 32'h101}, {32'h0_BEEF, 32'h3361}, 3'd0, 3, 1, 1'b0);
    // R6 execute encoded 2'b11 uses user read enable, hint 1
    walk("R6 exec11", 64'h0000_0000_0001_0000, 2'b11, 1'b1, 32'h41, 13,
         {32'h12, 32'h101}, {32'h13, 32'h101}, {32'h14, 32'h0221}, 3'd0, 3, 0, 1'b0);
    // R9 start pulsed while busy is ignored
    walk("R9 poke", 64'h0000_0000_0ABC_DEF0, 2'b00, 1'b0, 32'h42, 13,
         {32'h15, 32'h101}, {32'h16, 32'h101}, {32'h17, 32'h3301}, 3'd0, 3, 2, 1'b1);
    // R1 negative address with a bit cleared just above the width
    walk("R1 neg", 64'hFFFF_FB00_0000_0000, 2'b10, 1'b1, 32'h43, 13,
         64'h0, 64'h0, 64'h0, 3'd2, 0, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule